// File: doc/BRIEF.md
# Time-of-Year Calendar Counter

This block keeps wall-clock time from a slow crystal oscillator (nominally 32768 Hz). A programmable trim divider turns the oscillator into a once-per-second tick. Each tick advances a packed time word holding seconds, minutes, hours, day of month and month. The calendar year is kept on its own as a full binary year, for example 2024. Month lengths and leap Februaries follow the Gregorian rules over the years 1900 to 2099.

Software reaches the block over a simple register port that runs on the system clock. Writes of the time word, the year and the trim value are handed across to the oscillator domain by a toggle handshake. A busy bit in the control word stays set until the new value is loaded, so software polls it before the next write of that kind. Two more control bits report whether the oscillator domain is out of reset and whether oscillator edges are still arriving. Reads of the time, the year and the trim come straight from the oscillator-domain registers and are registered once on the system clock. Software should therefore read twice and compare if a tick may land between the reads.

Top module: `toy_cal`

## Requirements
- R1: The time word at read offset 0x0C packs its fields as follows: seconds in bits 9:4, minutes in 15:10, hour in 20:16, day in 25:21 and month in 31:26. Bits 3:0 always read 0. The year reads at 0x10 as a plain binary year. The trim reads at 0x00. The control word reads at 0x14, and write-only offsets read 0.
- R2: After reset the time word reads month 1, day 1, 00:00:00 (0x04200000), the year reads 2000 and the trim reads TRIM_RST. The control word reads 0 while the oscillator domain is still held in reset.
- R3: A write to offset 0x04 (time) or 0x08 (year) sets control bit 0 on the next system clock. The bit clears only after the value has been loaded, and the written value then reads back, with time bits 3:0 forced to 0.
- R4: A write to offset 0x00 sets control bit 4 until the new trim is in use. The new trim then reads back at 0x00.
- R5: A time or year write issued while bit 0 is set is dropped, and so is a trim write issued while bit 4 is set.
- R6: A tick occurs every trim+1 oscillator cycles. Any load of time, year or trim restarts the divider, so the first tick after a load comes trim+1 cycles later. A tick that coincides with a time or year load is dropped.
- R7: On a tick, seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R8: The day wraps to 1 after the last day of the month and carries into the month. April, June, September and November have 30 days. February has 29 days in years divisible by 4 other than 1900, and 28 days otherwise. All other months have 31 days.
- R9: Month 12 wraps to 1 and increments the year.
- R10: Control bit 8 reads 1 once the oscillator domain has left reset, after a two-flop synchronizer.
- R11: Control bit 5 reads 1 within a few system clocks of oscillator edges arriving. It clears after LOSS_CYCLES system clocks pass with no oscillator edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (register port) clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| osc_clk | input | 1 | Slow oscillator clock |
| osc_rst | input | 1 | Synchronous active-high reset, oscillator domain |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one system clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one clock after bus_addr |

## Verification
The assertions assume several things about the inputs:
- The oscillator runs several times slower than the system clock, so each handshake toggle is seen before the next one.
- Both resets are asserted together at start-up.
- The wrap checks on seconds and on the year-end step are written only for legal field values, so they assume software loads in-range fields.

The stimulus keeps within these limits in several ways:
- It drives a 100 ns oscillator against a 20 ns system clock, with edges offset so that the two never coincide.
- It loads only legal calendar dates.
- It waits for the busy bits to clear, except in the two back-to-back writes that deliberately test dropping.
- It times tick checks to the middle of a tick period, so the expected count is unambiguous.

// File: rtl/toy_pkg.sv
package toy_pkg;

    localparam int ADR_TRIM    = 'h00;
    localparam int ADR_TIME_WR = 'h04;
    localparam int ADR_YEAR_WR = 'h08;
    localparam int ADR_TIME_RD = 'h0C;
    localparam int ADR_YEAR_RD = 'h10;
    localparam int ADR_CTRL    = 'h14;

    localparam int CTRL_CAL_BUSY  = 0;
    localparam int CTRL_TRIM_BUSY = 4;
    localparam int CTRL_OSC_OK    = 5;
    localparam int CTRL_RUN       = 8;

    localparam logic [31:0] YEAR_RST = 32'd2000;

    // Field order fixes the bit offsets seen by software.
    typedef struct packed {
        logic [5:0] month;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] mins;
        logic [5:0] secs;
        logic [3:0] pad;
    } toy_time_t;

    typedef struct packed {
        logic [31:0] year;
        toy_time_t   tw;
    } toy_cal_t;

    localparam toy_time_t TIME_RST = '{month: 6'd1, day: 5'd1, hour: 5'd0,
                                       mins: 6'd0, secs: 6'd0, pad: 4'd0};

    function automatic logic is_leap(logic [31:0] y);
        return (y[1:0] == 2'b00) && (y != 32'd1900);
    endfunction

    function automatic logic [4:0] month_len(logic [5:0] m, logic [31:0] y);
        case (m)
            6'd2:                     return is_leap(y) ? 5'd29 : 5'd28;
            6'd4, 6'd6, 6'd9, 6'd11:  return 5'd30;
            default:                  return 5'd31;
        endcase
    endfunction

    function automatic toy_cal_t cal_step(toy_cal_t c);
        toy_cal_t n;
        n = c;
        if (c.tw.secs >= 6'd59) begin
            n.tw.secs = '0;
            if (c.tw.mins >= 6'd59) begin
                n.tw.mins = '0;
                if (c.tw.hour >= 5'd23) begin
                    n.tw.hour = '0;
                    if (c.tw.day >= month_len(c.tw.month, c.year)) begin
                        n.tw.day = 5'd1;
                        if (c.tw.month >= 6'd12) begin
                            n.tw.month = 6'd1;
                            n.year     = c.year + 32'd1;
                        end else begin
                            n.tw.month = c.tw.month + 6'd1;
                        end
                    end else begin
                        n.tw.day = c.tw.day + 5'd1;
                    end
                end else begin
                    n.tw.hour = c.tw.hour + 5'd1;
                end
            end else begin
                n.tw.mins = c.tw.mins + 6'd1;
            end
        end else begin
            n.tw.secs = c.tw.secs + 6'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/toy_xfer.sv
// Toggle handshake carrying one held word from the system clock into the
// oscillator domain. Busy lasts from the write until the load is acknowledged.
module toy_xfer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         osc_clk,
    input  logic         osc_rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         busy,
    output logic [W-1:0] held,
    output logic         ld
);
    logic         req_q, ack_s1, ack_s2;
    logic [W-1:0] data_q;
    logic         r1, r2, r3;

    assign busy = req_q ^ ack_s2;
    assign held = data_q;
    assign ld   = r2 ^ r3;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
            data_q <= '0;
        end else begin
            ack_s1 <= r3;
            ack_s2 <= ack_s1;
            if (wr && !busy) begin
                req_q  <= ~req_q;
                data_q <= wdata;
            end
        end
    end

    // r3 doubles as the acknowledge: it follows r2 on the edge that loads.
    always_ff @(posedge osc_clk) begin
        if (osc_rst) begin
            r1 <= 1'b0;
            r2 <= 1'b0;
            r3 <= 1'b0;
        end else begin
            r1 <= req_q;
            r2 <= r1;
            r3 <= r2;
        end
    end
endmodule

// File: rtl/toy_div.sv
module toy_div #(
    parameter int              TRIM_W   = 16,
    parameter logic [TRIM_W-1:0] TRIM_RST = '1
) (
    input  logic              osc_clk,
    input  logic              osc_rst,
    input  logic              trim_ld,
    input  logic [TRIM_W-1:0] trim_new,
    input  logic              restart,
    output logic              tick,
    output logic [TRIM_W-1:0] trim_q
);
    logic [TRIM_W-1:0] cnt;
    logic              clr;

    assign clr  = trim_ld || restart;
    assign tick = !clr && (cnt >= trim_q);

    always_ff @(posedge osc_clk) begin
        if (osc_rst) begin
            trim_q <= TRIM_RST;
            cnt    <= '0;
        end else begin
            if (trim_ld) trim_q <= trim_new;
            if (clr || tick) cnt <= '0;
            else             cnt <= cnt + TRIM_W'(1);
        end
    end
endmodule

// File: rtl/toy_clock.sv
module toy_clock
    import toy_pkg::*;
(
    input  logic        osc_clk,
    input  logic        osc_rst,
    input  logic        tick,
    input  logic        ld,
    input  logic        ld_year,
    input  logic [31:0] ld_data,
    output toy_time_t   time_q,
    output logic [31:0] year_q
);
    toy_cal_t nxt;

    assign nxt = cal_step('{year: year_q, tw: time_q});

    always_ff @(posedge osc_clk) begin
        if (osc_rst) begin
            time_q <= TIME_RST;
            year_q <= YEAR_RST;
        end else if (ld) begin
            if (ld_year) begin
                year_q <= ld_data;
            end else begin
                time_q     <= toy_time_t'(ld_data);
                time_q.pad <= '0;
            end
        end else if (tick) begin
            time_q <= nxt.tw;
            year_q <= nxt.year;
        end
    end
endmodule

// File: rtl/toy_osc_mon.sv
module toy_osc_mon #(
    parameter int LOSS_CYCLES = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_clk,
    input  logic osc_rst,
    output logic osc_ok,
    output logic osc_run
);
    localparam int CW = $clog2(LOSS_CYCLES + 1);

    logic          hb, run_q;
    logic          h1, h2, h3, u1, u2;
    logic [CW-1:0] gap;

    always_ff @(posedge osc_clk) begin
        if (osc_rst) begin
            hb    <= 1'b0;
            run_q <= 1'b0;
        end else begin
            hb    <= ~hb;
            run_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            {h1, h2, h3, u1, u2} <= '0;
            gap    <= '0;
            osc_ok <= 1'b0;
        end else begin
            h1 <= hb;
            h2 <= h1;
            h3 <= h2;
            u1 <= run_q;
            u2 <= u1;
            if (h2 ^ h3) begin
                gap    <= '0;
                osc_ok <= 1'b1;
            end else if (gap == CW'(LOSS_CYCLES - 1)) begin
                osc_ok <= 1'b0;
            end else begin
                gap <= gap + CW'(1);
            end
        end
    end

    assign osc_run = u2;
endmodule

// File: rtl/toy_cal.sv
module toy_cal
    import toy_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int TRIM_W      = 16,
    parameter int TRIM_RST    = 32767,
    parameter int LOSS_CYCLES = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_clk,
    input  logic              osc_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    logic              hit_time, hit_year, hit_trim;
    logic              cal_busy, trim_busy, cal_ld, trim_ld, tick;
    logic [32:0]       cal_held;
    logic [TRIM_W-1:0] trim_held, trim_q;
    toy_time_t         time_q;
    logic [31:0]       year_q, ctrl_w;
    logic              osc_ok, osc_run;

    assign hit_time = bus_addr == ADDR_W'(ADR_TIME_WR);
    assign hit_year = bus_addr == ADDR_W'(ADR_YEAR_WR);
    assign hit_trim = bus_addr == ADDR_W'(ADR_TRIM);

    // Time and year share one channel; bit 32 selects the year.
    toy_xfer #(.W(33)) u_cal_xfer (
        .clk(clk), .rst(rst), .osc_clk(osc_clk), .osc_rst(osc_rst),
        .wr(bus_wr && (hit_time || hit_year)), .wdata({hit_year, bus_wdata}),
        .busy(cal_busy), .held(cal_held), .ld(cal_ld)
    );

    toy_xfer #(.W(TRIM_W)) u_trim_xfer (
        .clk(clk), .rst(rst), .osc_clk(osc_clk), .osc_rst(osc_rst),
        .wr(bus_wr && hit_trim), .wdata(bus_wdata[TRIM_W-1:0]),
        .busy(trim_busy), .held(trim_held), .ld(trim_ld)
    );

    toy_div #(.TRIM_W(TRIM_W), .TRIM_RST(TRIM_W'(TRIM_RST))) u_div (
        .osc_clk(osc_clk), .osc_rst(osc_rst), .trim_ld(trim_ld),
        .trim_new(trim_held), .restart(cal_ld), .tick(tick), .trim_q(trim_q)
    );

    toy_clock u_clock (
        .osc_clk(osc_clk), .osc_rst(osc_rst), .tick(tick), .ld(cal_ld),
        .ld_year(cal_held[32]), .ld_data(cal_held[31:0]),
        .time_q(time_q), .year_q(year_q)
    );

    toy_osc_mon #(.LOSS_CYCLES(LOSS_CYCLES)) u_mon (
        .clk(clk), .rst(rst), .osc_clk(osc_clk), .osc_rst(osc_rst),
        .osc_ok(osc_ok), .osc_run(osc_run)
    );

    always_comb begin
        ctrl_w                 = '0;
        ctrl_w[CTRL_CAL_BUSY]  = cal_busy;
        ctrl_w[CTRL_TRIM_BUSY] = trim_busy;
        ctrl_w[CTRL_OSC_OK]    = osc_ok;
        ctrl_w[CTRL_RUN]       = osc_run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            case (bus_addr)
                ADDR_W'(ADR_TRIM):    bus_rdata <= 32'(trim_q);
                ADDR_W'(ADR_TIME_RD): bus_rdata <= time_q;
                ADDR_W'(ADR_YEAR_RD): bus_rdata <= year_q;
                ADDR_W'(ADR_CTRL):    bus_rdata <= ctrl_w;
                default:              bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/toy_cal_chk.sv
module toy_cal_chk #(
    parameter int ADDR_W = 5,
    parameter int TRIM_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              osc_clk,
    input logic              osc_rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              cal_busy,
    input logic              trim_busy,
    input logic [32:0]       cal_held,
    input logic [TRIM_W-1:0] trim_held,
    input logic              tick,
    input logic              cal_ld,
    input logic [31:0]       time_q,
    input logic [31:0]       year_q
);
    logic cal_wr, trim_wr;
    assign cal_wr  = bus_wr && (bus_addr == ADDR_W'('h04) || bus_addr == ADDR_W'('h08));
    assign trim_wr = bus_wr && (bus_addr == ADDR_W'('h00));

    a_r3_busy_set: assert property (@(posedge clk) disable iff (rst)
        (cal_wr && !cal_busy) |=> cal_busy);

    a_r4_busy_set: assert property (@(posedge clk) disable iff (rst)
        (trim_wr && !trim_busy) |=> trim_busy);

    a_r5_cal_drop: assert property (@(posedge clk) disable iff (rst)
        (cal_wr && cal_busy) |=> $stable(cal_held));

    a_r5_trim_drop: assert property (@(posedge clk) disable iff (rst)
        (trim_wr && trim_busy) |=> $stable(trim_held));

    a_r6_hold: assert property (@(posedge osc_clk) disable iff (osc_rst)
        (!tick && !cal_ld) |=> ($stable(time_q) && $stable(year_q)));

    a_r7_sec_wrap: assert property (@(posedge osc_clk) disable iff (osc_rst)
        (tick && !cal_ld && time_q[9:4] == 6'd59) |=> (time_q[9:4] == 6'd0));

    a_r9_year_step: assert property (@(posedge osc_clk) disable iff (osc_rst)
        (tick && !cal_ld && time_q[31:4] == {6'd12, 5'd31, 5'd23, 6'd59, 6'd59})
        |=> (year_q == $past(year_q) + 32'd1 && time_q[31:26] == 6'd1));

    a_r1_pad_zero: assert property (@(posedge osc_clk) disable iff (osc_rst)
        1'b1 |=> (time_q[3:0] == 4'd0));
endmodule

bind toy_cal toy_cal_chk #(.ADDR_W(ADDR_W), .TRIM_W(TRIM_W)) u_chk (
    .clk(clk), .rst(rst), .osc_clk(osc_clk), .osc_rst(osc_rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .cal_busy(cal_busy),
    .trim_busy(trim_busy), .cal_held(cal_held), .trim_held(trim_held),
    .tick(tick), .cal_ld(cal_ld), .time_q(time_q), .year_q(year_q)
);

// File: tb/toy_cal_bench.sv
module toy_cal_bench;
    localparam int AW = 5;
    localparam logic [31:0] ALL = 32'hFFFF_FFFF;

    logic          clk = 1'b0, rst = 1'b1, osc_clk = 1'b0, osc_rst = 1'b1, osc_run = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    toy_cal #(.ADDR_W(AW), .TRIM_W(16), .TRIM_RST(39), .LOSS_CYCLES(64)) u_toy_cal (
        .clk(clk), .rst(rst), .osc_clk(osc_clk), .osc_rst(osc_rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;
    initial begin
        #7;
        forever begin
            #50;
            if (osc_run) osc_clk = ~osc_clk;
        end
    end

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;
    item_t sb_q[$];
    int    total = 0, bad = 0;
    logic  go = 1'b0, pend = 1'b0;

    // Monitor: one read result per strobe, compared against the queue head.
    always @(posedge clk) pend <= go;
    always @(negedge clk) begin
        if (pend) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if ((bus_rdata & it.mask) !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, bus_rdata & it.mask, it.exp);
            end
        end
    end

    function automatic logic [31:0] tw(int mo, int d, int h, int mi, int s);
        return 32'((mo << 26) | (d << 21) | (h << 16) | (mi << 10) | (s << 4));
    endfunction

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(int a, logic [31:0] e, logic [31:0] m, string tag);
        item_t it;
        @(negedge clk);
        bus_addr = AW'(a);
        it.exp = e & m; it.mask = m; it.tag = tag;
        sb_q.push_back(it);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_idle(logic [31:0] m, string tag);
        int n;
        n = 0;
        @(negedge clk);
        bus_addr = AW'('h14);
        @(negedge clk);
        while ((bus_rdata & m) != 0 && n < 500) begin
            @(negedge clk);
            n++;
        end
        if (n >= 500) begin
            total++; bad++;
            $display("FAIL %s: busy stuck actual=%h expected=0", tag, bus_rdata & m);
        end
    endtask

    task automatic set_cal(int y, logic [31:0] t);
        wr('h08, 32'(y));
        rd('h14, 32'h1, 32'h1, "R3 busy after year write");
        wait_idle(32'h1, "R3");
        wr('h04, t);
        wait_idle(32'h1, "R3");
    endtask

    // Load a date, check it reads back, then check after k ticks of period p.
    task automatic roll(int y, logic [31:0] t, int k, int p, int ey, logic [31:0] et, string tag);
        set_cal(y, t);
        rd('h0C, t & ~32'hF, ALL, "R3 time readback");
        rd('h10, 32'(y), ALL, "R3 year readback");
        idle(k * p + p / 2 - 16);
        rd('h0C, et, ALL, tag);
        rd('h10, 32'(ey), ALL, tag);
    endtask

    initial begin
        idle(10);
        rst = 1'b0;
        idle(10);
        rd('h14, 32'h0, ALL, "R2 R10 ctrl while osc in reset");
        rd('h0C, 32'h0420_0000, ALL, "R2 time reset");
        rd('h10, 32'd2000, ALL, "R2 year reset");
        rd('h00, 32'd39, ALL, "R2 trim reset");
        rd('h04, 32'h0, ALL, "R1 write-only offset reads 0");
        osc_rst = 1'b0;
        idle(30);
        rd('h14, 32'h120, 32'h131, "R10 R11 running and clock present");

        // Trim 19: 20 oscillator cycles = 100 system clocks per tick.
        wr('h00, 32'd19);
        wr('h00, 32'd5);
        rd('h14, 32'h10, 32'h10, "R4 trim busy");
        wait_idle(32'h10, "R4");
        rd('h00, 32'd19, ALL, "R4 R5 trim readback, second write dropped");

        // Dropped time write while busy.
        set_cal(2024, tw(6, 15, 12, 34, 56) | 32'hF);
        rd('h0C, tw(6, 15, 12, 34, 56), ALL, "R1 time layout, pad bits zero");
        wr('h04, tw(3, 3, 3, 3, 3));
        wr('h04, tw(9, 9, 9, 9, 9));
        wait_idle(32'h1, "R5");
        rd('h0C, tw(3, 3, 3, 3, 3), ALL, "R5 time write while busy dropped");

        roll(2024, tw(6, 15, 12, 34, 56), 4, 100, 2024, tw(6, 15, 12, 35, 0), "R7 R6 seconds carry");
        roll(2023, tw(2, 28, 23, 59, 59), 1, 100, 2023, tw(3, 1, 0, 0, 0), "R8 Feb 28 non-leap");
        roll(2024, tw(2, 28, 23, 59, 59), 1, 100, 2024, tw(2, 29, 0, 0, 0), "R8 Feb 29 leap");
        roll(2024, tw(2, 29, 23, 59, 59), 1, 100, 2024, tw(3, 1, 0, 0, 0), "R8 leap day end");
        roll(1900, tw(2, 28, 23, 59, 59), 1, 100, 1900, tw(3, 1, 0, 0, 0), "R8 1900 not leap");
        roll(2023, tw(4, 30, 23, 59, 59), 1, 100, 2023, tw(5, 1, 0, 0, 0), "R8 30-day month");
        roll(2023, tw(1, 31, 23, 59, 59), 1, 100, 2023, tw(2, 1, 0, 0, 0), "R8 31-day month");
        roll(1999, tw(12, 31, 23, 59, 59), 1, 100, 2000, tw(1, 1, 0, 0, 0), "R9 year rollover");
        roll(2010, tw(5, 5, 10, 59, 58), 2, 100, 2010, tw(5, 5, 11, 0, 0), "R7 minute/hour carry");

        // Trim 9: 10 oscillator cycles = 50 system clocks per tick.
        wr('h00, 32'd9);
        wait_idle(32'h10, "R4");
        rd('h00, 32'd9, ALL, "R4 new trim readback");
        roll(2001, tw(1, 1, 0, 0, 0), 7, 50, 2001, tw(1, 1, 0, 0, 7), "R6 tick period follows trim");

        osc_run = 1'b0;
        idle(150);
        rd('h14, 32'h0, 32'h20, "R11 clock loss clears present");
        osc_run = 1'b1;
        idle(20);
        rd('h14, 32'h20, 32'h20, "R11 clock return sets present");

        idle(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule